// File: doc/BRIEF.md
# Signed-Count Bidirectional Logical Shifter

This block is a purely combinational logical shifter. The shift direction comes from the sign of a two's-complement count field. A positive count moves the data toward the most significant end. A negative count moves it toward the least significant end by the magnitude of the count. Vacated positions are always filled with zeros. Only the low bits of the 32-bit count operand form the count field; the rest of the operand plays no part.

A mode input picks between two layouts. In word mode the 32-bit operand is shifted as a single value. In halfword mode the operand is treated as two independent 16-bit lanes, and both lanes are shifted by the same count. The most negative count in each mode has no matching shift amount, so it is decoded as a request to clear the whole result.

The block sits in an execution pipeline between operand selection and result write-back. It holds no state, so a result is valid in the same cycle as its operands.

Top module: `signed_count_shifter`

## Requirements
- R1: With `halfMode` = 0 (word mode), the count is `countIn[5:0]` read as a signed 6-bit value in the range -32 to +31.
- R2: With `halfMode` = 1 (halfword mode), the count is `countIn[4:0]` read as a signed 5-bit value in the range -16 to +15.
- R3: In word mode, a positive count n gives `dataIn` shifted left by n. The low n bits become zero, and bits shifted past bit 31 are lost.
- R4: In word mode, a negative count -n (1 ≤ n ≤ 31) gives `dataIn` shifted right logically by n, with zeros entering at bit 31.
- R5: In word mode, a count field of 6'b100000 (-32) gives an all-zero result.
- R6: In halfword mode, a count field of 5'b10000 (-16) gives an all-zero result.
- R7: In halfword mode, the lower lane `dataIn[15:0]` and the upper lane `dataIn[31:16]` are each shifted logically by the same count. Each result is truncated to 16 bits. Bits leaving either lane never enter the other lane.
- R8: Bits of `countIn` above the count field of the active mode have no effect on `dataOut`.
- R9: A count field equal to zero passes `dataIn` to `dataOut` unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 32 | Operand to be shifted |
| countIn | input | 32 | Count operand; only the low 6 (word) or 5 (halfword) bits are used |
| halfMode | input | 1 | 0 selects word mode, 1 selects two 16-bit lanes |
| dataOut | output | 32 | Shifted result |

## Verification
There is no register between the ports, so every result is due in the same cycle as the operands that produce it, with zero cycles of latency. The bench applies each new operand set just after a rising clock edge and compares `dataOut` at the following falling edge. By then the combinational path has settled, and the next stimulus has not yet arrived. Directed vectors cover the clear counts, the extreme shift amounts in each mode, lane isolation, and junk in the unused count bits. A pseudo-random sweep then compares both modes against a behavioural model on every clock.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  localparam int DATA_W = 32;
  localparam int LANE_W = 16;
  localparam int AMT_W  = $clog2(DATA_W);

  // Strobes from the count decoder to the shifting datapath.
  typedef struct packed {
    logic             laneMode;
    logic             goLeft;
    logic             zeroOut;
    logic [AMT_W-1:0] amount;
  } shift_ctrl_t;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shifter_pkg::*;
#(
  parameter int DATA_W = shifter_pkg::DATA_W,
  parameter int LANE_W = shifter_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] countIn,
  input  logic              halfMode,
  output shift_ctrl_t       ctrl
);

  localparam int WAMT_W = $clog2(DATA_W);
  localparam int LAMT_W = $clog2(LANE_W);
  localparam int WCNT_W = WAMT_W + 1;
  localparam int LCNT_W = LAMT_W + 1;

  logic [WCNT_W-1:0] wordField;
  logic [LCNT_W-1:0] laneField;
  logic [WCNT_W-1:0] wordMag;
  logic [LCNT_W-1:0] laneMag;
  logic              wordNeg;
  logic              laneNeg;
  logic              unusedCountBits;

  assign wordField = countIn[WCNT_W-1:0];
  assign laneField = countIn[LCNT_W-1:0];
  assign wordNeg   = wordField[WCNT_W-1];
  assign laneNeg   = laneField[LCNT_W-1];
  assign unusedCountBits = ^countIn[DATA_W-1:WCNT_W];

  // Magnitude of the signed field; the most negative code maps to a value
  // whose top bit is set, which is the clear request.
  assign wordMag = wordNeg ? (~wordField + WCNT_W'(1)) : wordField;
  assign laneMag = laneNeg ? (~laneField + LCNT_W'(1)) : laneField;

  always_comb begin
    ctrl.laneMode = halfMode;
    if (halfMode) begin
      ctrl.goLeft  = ~laneNeg;
      ctrl.zeroOut = laneMag[LCNT_W-1];
      ctrl.amount  = AMT_W'(laneMag[LAMT_W-1:0]);
    end else begin
      ctrl.goLeft  = ~wordNeg;
      ctrl.zeroOut = wordMag[WCNT_W-1];
      ctrl.amount  = wordMag[AMT_W-1:0];
    end
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int DATA_W = shifter_pkg::DATA_W,
  parameter int LANE_W = shifter_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] dataIn,
  input  shift_ctrl_t       ctrl,
  output logic [DATA_W-1:0] dataOut
);

  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int LAMT_W    = $clog2(LANE_W);

  logic [DATA_W-1:0] wordRes;
  logic [DATA_W-1:0] laneRes;
  logic [LAMT_W-1:0] laneAmt;

  assign laneAmt = ctrl.amount[LAMT_W-1:0];
  assign wordRes = ctrl.goLeft ? (dataIn << ctrl.amount) : (dataIn >> ctrl.amount);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneIn;
    assign laneIn = dataIn[l*LANE_W +: LANE_W];
    assign laneRes[l*LANE_W +: LANE_W] =
      ctrl.goLeft ? (laneIn << laneAmt) : (laneIn >> laneAmt);
  end

  always_comb begin
    if (ctrl.zeroOut)       dataOut = '0;
    else if (ctrl.laneMode) dataOut = laneRes;
    else                    dataOut = wordRes;
  end

endmodule

// File: rtl/signed_count_shifter.sv
module signed_count_shifter
  import shifter_pkg::*;
#(
  parameter int DATA_W = shifter_pkg::DATA_W,
  parameter int LANE_W = shifter_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] countIn,
  input  logic              halfMode,
  output logic [DATA_W-1:0] dataOut
);

  localparam int WCNT_W = $clog2(DATA_W) + 1;
  localparam int LCNT_W = $clog2(LANE_W) + 1;

  shift_ctrl_t ctrl;

  shift_decode #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_decode (
    .countIn (countIn),
    .halfMode(halfMode),
    .ctrl    (ctrl)
  );

  shift_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_datapath (
    .dataIn (dataIn),
    .ctrl   (ctrl),
    .dataOut(dataOut)
  );

  // Port-level checks on the decoded count against the datapath result.
  logic [WCNT_W-1:0] chkWord;
  logic [LCNT_W-1:0] chkLane;
  assign chkWord = countIn[WCNT_W-1:0];
  assign chkLane = countIn[LCNT_W-1:0];

  always_comb begin
    if (!halfMode) begin
      if (chkWord == {1'b1, {(WCNT_W-1){1'b0}}})
        assert_word_clear_R5: assert (dataOut == '0) else $error("word clear count gave nonzero");
      if (chkWord == '0)
        assert_word_pass_R9: assert (dataOut == dataIn) else $error("word zero count altered data");
      if (!chkWord[WCNT_W-1] && chkWord != '0)
        assert_word_left_fill_R3: assert (dataOut[0] == 1'b0) else $error("left shift bit 0 set");
      if (chkWord[WCNT_W-1])
        assert_word_right_fill_R4: assert (dataOut[DATA_W-1] == 1'b0) else $error("right shift msb set");
    end else begin
      if (chkLane == {1'b1, {(LCNT_W-1){1'b0}}})
        assert_lane_clear_R6: assert (dataOut == '0) else $error("lane clear count gave nonzero");
      if (chkLane == '0)
        assert_lane_pass_R9: assert (dataOut == dataIn) else $error("lane zero count altered data");
      if (!chkLane[LCNT_W-1] && chkLane != '0)
        assert_lane_left_isolate_R7: assert (dataOut[LANE_W] == 1'b0 && dataOut[0] == 1'b0)
          else $error("lane left shift leaked");
      if (chkLane[LCNT_W-1])
        assert_lane_right_isolate_R7: assert (dataOut[LANE_W-1] == 1'b0 && dataOut[DATA_W-1] == 1'b0)
          else $error("lane right shift leaked");
    end
  end

endmodule

// File: tb/signed_count_shifter_bench.sv
module signed_count_shifter_bench;

  logic        clk = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] countIn = '0;
  logic        halfMode = 1'b0;
  logic [31:0] dataOut;
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  signed_count_shifter u_signed_count_shifter (
    .dataIn  (dataIn),
    .countIn (countIn),
    .halfMode(halfMode),
    .dataOut (dataOut)
  );

  function automatic logic [31:0] refShift(logic [31:0] d, logic [31:0] c, logic h);
    int n;
    logic [31:0] r;
    logic [15:0] lane;
    if (!h) begin
      n = int'(c[5:0]);
      if (n >= 32) n -= 64;
      if (n == -32) return 32'h0;
      if (n >= 0) return d << n;
      return d >> (-n);
    end
    n = int'(c[4:0]);
    if (n >= 16) n -= 32;
    if (n == -16) return 32'h0;
    for (int l = 0; l < 2; l++) begin
      lane = d[l*16 +: 16];
      if (n >= 0) lane = lane << n;
      else        lane = lane >> (-n);
      r[l*16 +: 16] = lane;
    end
    return r;
  endfunction

  task automatic apply(input logic [31:0] d, input logic [31:0] c, input logic h,
                       input logic [31:0] exp, input string tag);
    @(posedge clk);
    #1;
    dataIn = d; countIn = c; halfMode = h;
    @(negedge clk);
    compared++;
    if (dataOut !== exp) begin
      mismatched++;
      $display("FAIL %s: data=%h count=%h half=%0b actual=%h expected=%h",
               tag, d, c, h, dataOut, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] c;
    logic        h;
    repeat (3) @(posedge clk);
    // Idle state: all-zero operands give zero (R9)
    apply(32'h0, 32'h0, 1'b0, 32'h0, "R9 idle");
    // R1: full word range
    apply(32'h0000_0001, 32'h0000_001F, 1'b0, 32'h8000_0000, "R1 +31");
    apply(32'h8000_0000, 32'h0000_003F, 1'b0, 32'h4000_0000, "R1 -1");
    apply(32'h0000_FFFF, 32'h0000_0010, 1'b0, 32'hFFFF_0000, "R1 +16 word");
    apply(32'h8000_0000, 32'h0000_0021, 1'b0, 32'h0000_0001, "R1 -31");
    // R2: halfword range
    apply(32'h0001_0001, 32'h0000_000F, 1'b1, 32'h8000_8000, "R2 +15");
    apply(32'h8000_8000, 32'h0000_001F, 1'b1, 32'h4000_4000, "R2 -1");
    apply(32'h8000_8000, 32'h0000_0011, 1'b1, 32'h0001_0001, "R2 -15");
    // R3 / R4: word direction and fill
    apply(32'h0000_00F1, 32'h0000_0004, 1'b0, 32'h0000_0F10, "R3 left 4");
    apply(32'hF000_0000, 32'h0000_003C, 1'b0, 32'h0F00_0000, "R4 right 4");
    apply(32'hFFFF_FFFF, 32'h0000_0038, 1'b0, 32'h00FF_FFFF, "R4 right 8 zero fill");
    // R5 / R6: clear counts
    apply(32'hFFFF_FFFF, 32'h0000_0020, 1'b0, 32'h0, "R5 word -32");
    apply(32'hFFFF_FFFF, 32'h0000_0010, 1'b1, 32'h0, "R6 half -16");
    // R7: lane independence and truncation
    apply(32'hF00F_F00F, 32'h0000_0004, 1'b1, 32'h00F0_00F0, "R7 left trunc");
    apply(32'h00F0_00F0, 32'h0000_001C, 1'b1, 32'h000F_000F, "R7 right 4");
    apply(32'h0000_8000, 32'h0000_0001, 1'b1, 32'h0000_0000, "R7 no carry up");
    apply(32'h0001_0000, 32'h0000_001F, 1'b1, 32'h0000_0000, "R7 no carry down");
    // R8: junk above the field
    apply(32'h0000_00F1, 32'hFFFF_FF04, 1'b0, 32'h0000_0F10, "R8 word junk");
    apply(32'h0001_0001, 32'hFFFF_FFE3, 1'b1, 32'h0008_0008, "R8 half junk");
    apply(32'h1234_5678, 32'hFFFF_FFC0, 1'b0, 32'h1234_5678, "R8 word junk zero field");
    // R9: pass-through
    apply(32'hDEAD_BEEF, 32'h0000_0000, 1'b0, 32'hDEAD_BEEF, "R9 word");
    apply(32'hDEAD_BEEF, 32'h0000_0020, 1'b1, 32'hDEAD_BEEF, "R9 half field zero");
    // Sweep against the model
    for (int i = 0; i < 3000; i++) begin
      d = $urandom;
      c = $urandom;
      h = 1'($urandom);
      apply(d, c, h, refShift(d, c, h), h ? "R7 R2 sweep" : "R1 R3 R4 sweep");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule